// File: doc/BRIEF.md
# Three-Wire Bus Arbitration Controller

This block sits in the local bus controller and hands the shared external bus to other masters through a three-wire handshake: request, grant and grant-acknowledge. The local processor always has the lowest priority. When an external master raises its request, the block stops the local engine from starting new cycles. It raises the grant only when the local engine reports an operand-transfer boundary and no locked read-modify-write sequence is in flight. It then tracks ownership on the acknowledge line rather than on its own grant.

Priority among several external masters is resolved outside this block. Chip-select outputs are not affected by it and stay driven throughout. The request and acknowledge inputs come from other clock domains, so they can pass through a synchroniser whose depth is a parameter. The default depth of zero suits a system where they are already synchronous. There is no data stream at this block's edge, so every pin is a plain level-sensitive control signal.

Top module: `bus_arbiter3w`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_grant` is 0 and `local_go` is 1.
- R2: A request seen while idle moves the block to the pending state on that clock edge, and never to the grant state directly. From then on `local_go` is 0 unless `rmw_lock` is 1.
- R3: In the pending state, `bus_grant` rises on the clock after a cycle in which the request is still present, `xfer_end` is 1, `rmw_lock` is 0 and the acknowledge is 0.
- R4: While `rmw_lock` is 1, no grant is issued even at a transfer boundary, and `local_go` stays 1 so the locked sequence can finish.
- R5: Once raised, `bus_grant` stays 1 while the request stays present and the acknowledge stays 0.
- R6: If the request is withdrawn before the acknowledge appears, whether pending or granted, the next clock returns the block to idle with `bus_grant` 0 and `local_go` 1.
- R7: An acknowledge seen while granted drops `bus_grant` on the next clock, and `local_go` stays 0 for as long as the acknowledge is held. The acknowledge takes precedence over a request withdrawn in the same cycle.
- R8: One clock after the acknowledge is seen low, `local_go` returns to 1 if no request is present. If a request is present, the block goes back to pending instead.
- R9: An acknowledge seen with no grant outstanding, from a master granted elsewhere, also moves the block to external ownership and blocks the local engine on the next clock.
- R10: `bus_grant` and `local_go` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req | input | 1 | Bus request from external masters, active high |
| ext_ack | input | 1 | Grant acknowledge; high for the whole external tenure |
| xfer_end | input | 1 | Local engine is at an operand boundary or idle |
| rmw_lock | input | 1 | Local read-modify-write sequence in progress |
| bus_grant | output | 1 | Bus grant to external masters |
| local_go | output | 1 | Local engine may start a new bus cycle |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a transfer boundary arriving in the very cycle the request is withdrawn. The second is the acknowledge rising in the very cycle the request drops while granted. The bench drives each pair together in one cycle. In the first case it expects idle with no grant. In the second it expects external ownership, with both the grant and `local_go` low. A reset applied in the middle of a grant is also checked at the ports.

// File: rtl/arb3w_pkg.sv
package arb3w_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_PEND    = 2'd1,
    ARB_GRANTED = 2'd2,
    ARB_EXT     = 2'd3
  } arb_state_t;
endpackage

// File: rtl/arb3w_sync.sv
module arb3w_sync #(
  parameter int STAGES = 0,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/arb3w_permit.sv
module arb3w_permit (
  input  logic req,
  input  logic xfer_end,
  input  logic rmw_lock,
  output logic slot_ok
);
  // A handover slot exists only at an operand boundary outside a locked sequence.
  always_comb slot_ok = req & xfer_end & ~rmw_lock;
endmodule

// File: rtl/arb3w_fsm.sv
module arb3w_fsm
  import arb3w_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       ack,
  input  logic       slot_ok,
  input  logic       rmw_lock,
  output arb_state_t state,
  output logic       grant,
  output logic       local_go
);
  arb_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ARB_IDLE: begin
        if (ack)      nxt = ARB_EXT;
        else if (req) nxt = ARB_PEND;
      end
      ARB_PEND: begin
        if (ack)          nxt = ARB_EXT;
        else if (!req)    nxt = ARB_IDLE;
        else if (slot_ok) nxt = ARB_GRANTED;
      end
      ARB_GRANTED: begin
        if (ack)       nxt = ARB_EXT;
        else if (!req) nxt = ARB_IDLE;
      end
      ARB_EXT: begin
        if (!ack) nxt = req ? ARB_PEND : ARB_IDLE;
      end
      default: nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ARB_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    grant    = (state == ARB_GRANTED);
    local_go = (state == ARB_IDLE) || ((state == ARB_PEND) && rmw_lock);
  end
endmodule

// File: rtl/bus_arbiter3w.sv
module bus_arbiter3w
  import arb3w_pkg::*;
#(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic ext_ack,
  input  logic xfer_end,
  input  logic rmw_lock,
  output logic bus_grant,
  output logic local_go
);
  localparam int EXT_LINES = 2;

  logic [EXT_LINES-1:0] ext_raw;
  logic [EXT_LINES-1:0] ext_syn;
  logic                 req_s;
  logic                 ack_s;
  logic                 slot_ok;
  arb_state_t           state;

  assign ext_raw = {ext_ack, ext_req};

  arb3w_sync #(.STAGES(SYNC_STAGES), .WIDTH(EXT_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_raw),
    .q     (ext_syn)
  );

  assign req_s = ext_syn[0];
  assign ack_s = ext_syn[1];

  arb3w_permit u_permit (
    .req      (req_s),
    .xfer_end (xfer_end),
    .rmw_lock (rmw_lock),
    .slot_ok  (slot_ok)
  );

  arb3w_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_s),
    .ack      (ack_s),
    .slot_ok  (slot_ok),
    .rmw_lock (rmw_lock),
    .state    (state),
    .grant    (bus_grant),
    .local_go (local_go)
  );
endmodule

// File: rtl/arb3w_chk.sv
module arb3w_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ack,
  input logic xfer_end,
  input logic rmw_lock,
  input logic grant,
  input logic local_go
);
  // R3
  grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> ($past(xfer_end) && !$past(ack)));

  // R4
  grant_not_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> !$past(rmw_lock));

  // R2
  grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(req));

  // R6
  withdraw_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req && !ack) |=> (!grant && local_go));

  // R7
  ack_drops_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && ack) |=> !grant);

  // R9
  ack_blocks_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !local_go);

  // R10
  no_dual_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && local_go));
endmodule

bind bus_arbiter3w arb3w_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req_s),
  .ack      (ack_s),
  .xfer_end (xfer_end),
  .rmw_lock (rmw_lock),
  .grant    (bus_grant),
  .local_go (local_go)
);

// File: tb/bus_arbiter3w_test.sv
`timescale 1ns/1ps
module bus_arbiter3w_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req = 1'b0;
  logic ext_ack = 1'b0;
  logic xfer_end = 1'b0;
  logic rmw_lock = 1'b0;
  logic bus_grant;
  logic local_go;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_arbiter3w uut (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_ack(ext_ack),
    .xfer_end(xfer_end), .rmw_lock(rmw_lock),
    .bus_grant(bus_grant), .local_go(local_go)
  );

  // Row fields: {ext_req, ext_ack, xfer_end, rmw_lock, exp bus_grant, exp local_go}
  localparam int NV = 22;
  localparam logic [5:0] VEC [NV] = '{
    6'b0000_01, // idle                          R1
    6'b1000_00, // request -> pending            R2
    6'b1000_00, // no boundary yet               R3
    6'b1010_10, // boundary -> granted           R3
    6'b1000_10, // grant held                    R5
    6'b1100_00, // ack -> owned                  R7
    6'b0100_00, // tenure continues              R7
    6'b0000_01, // ack gone -> local             R8
    6'b1001_01, // request during lock           R4
    6'b1011_01, // boundary under lock, held off R4
    6'b1010_10, // lock ends -> granted          R4
    6'b1100_00, // ack                           R7
    6'b1000_00, // ack gone, new request         R8
    6'b1010_10, // granted again                 R3
    6'b0000_01, // withdrawn while granted       R6
    6'b1000_00, // pending                       R2
    6'b0000_01, // withdrawn while pending       R6
    6'b0100_00, // foreign owner                 R9
    6'b0000_01, // foreign owner leaves          R8
    6'b1010_00, // boundary at request: pending  R2
    6'b1110_00, // ack while pending             R9
    6'b0000_01  // back to idle                  R8
  };
  localparam logic [15:0] TAG [NV] = '{
    "R1","R2","R3","R3","R5","R7","R7","R8","R4","R4","R4",
    "R7","R8","R3","R6","R2","R6","R9","R8","R2","R9","R8"
  };

  task automatic chk(input logic [15:0] tag, input logic [1:0] exp);
    checks++;
    if ({bus_grant, local_go} !== exp) begin
      errors++;
      $display("FAIL %s: grant,go got %b expected %b", tag, {bus_grant, local_go}, exp);
    end
    // R10: the two outputs are exclusive
    checks++;
    if (bus_grant && local_go) begin
      errors++;
      $display("FAIL R10: grant,go got 11 expected not both high");
    end
  endtask

  task automatic step(input logic br, input logic ba, input logic xe, input logic rl);
    @(negedge clk);
    ext_req = br; ext_ack = ba; xfer_end = xe; rmw_lock = rl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    chk("R1", 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", 2'b01);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk(TAG[i], VEC[i][1:0]);
    end

    // R6 collision: boundary arrives in the cycle the request drops
    step(1, 0, 0, 0); chk("R2", 2'b00);
    step(0, 0, 1, 0); chk("R6", 2'b01);

    // R7 collision: ack rises as the request drops while granted
    step(1, 0, 0, 0);
    step(1, 0, 1, 0); chk("R3", 2'b10);
    step(0, 1, 0, 0); chk("R7", 2'b00);

    // R8 timing: go stays low until the edge after ack is seen low
    @(negedge clk);
    ext_ack = 1'b0;
    #1;
    chk("R8", 2'b00);
    @(posedge clk);
    #1;
    chk("R8", 2'b01);

    // R1: reset in the middle of a grant
    step(1, 0, 0, 0);
    step(1, 0, 1, 0); chk("R5", 2'b10);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", 2'b01);
    @(negedge clk);
    ext_req = 1'b0; xfer_end = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule